// File: doc/BRIEF.md
# Almost-Flag Offset Register Loader

This block fills the four threshold registers that a pair of FIFOs uses for their almost-empty and almost-full warnings. There is one almost-full threshold and one almost-empty threshold for each port. The block supports three ways of loading them, and the choice is made once, from the levels on a program-mode pin and two flag-select pins at the first clock edge after reset is released.

The first way is a fixed preset, which goes into all four registers at once. The second is a parallel load taken from the first four data-bus write strobes. The third is a serial load, where the two flag-select pins change role and act as a data bit and an active-low shift enable.

Until loading completes, the block holds a ready gate low. That gate is meant to be ANDed into both FIFOs' write-ready flags. While the gate is low, bus writes are kept away from FIFO memory. When loading completes, the block raises a done signal and opens the gate. From then on, every write strobe passes through to memory and the registers stay frozen until the next reset. Comparing the thresholds against fill levels is left to the FIFOs.

Top module: `ofs_loader`

## Requirements
- R1: While reset is asserted and until the selection edge, all four offset outputs read 0, and `prog_done_o`, `rdy_gate_o` and `mem_wr_o` are low.
- R2: At the selection edge (the first rising clock edge after reset is released), if `prog_mode_i` is 1 and both flag-select pins are 1, all four offsets become 64. `prog_done_o` and `rdy_gate_o` go high on that same edge.
- R3: At the selection edge with `prog_mode_i` 1, if only `fsel1_sen_i` is 1 the preset is 16, and if only `fsel0_sd_i` is 1 the preset is 8. Either preset goes into all four registers, and done rises on that edge.
- R4: At the selection edge with `prog_mode_i` 1 and both flag-select pins 0, parallel loading is chosen. Each later edge with `wr_en_i` high loads `wr_data_i[8:0]` into the next register, in this order: almost-full A, almost-empty B, almost-full B, almost-empty A. Bus bits above bit 8 are ignored, and edges without a strobe do not advance the order.
- R5: In parallel loading, `prog_done_o` and `rdy_gate_o` go high on the edge that takes the fourth strobe.
- R6: At the selection edge, if `prog_mode_i` is 0, serial loading is chosen whatever the flag-select pins are. After that, each edge with `fsel1_sen_i` low shifts in `fsel0_sd_i`. Edges with `fsel1_sen_i` high shift nothing.
- R7: The serial stream is 36 bits long. The first bit is the MSB of almost-full A, the order of registers is the same as in R4, and the last bit is the LSB of almost-empty A.
- R8: In serial loading, `prog_done_o` and `rdy_gate_o` stay low through the edge that takes the 36th bit and rise on the next edge. Bits offered on that next edge are ignored.
- R9: `mem_wr_o` equals `wr_en_i` while `prog_done_o` is high and is 0 otherwise. In preset or serial loading, and at the selection edge, write strobes change no register.
- R10: Once `prog_done_o` is high, it and all four offsets stay unchanged until reset, whatever happens on the pins, the strobe or the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode_i | input | 1 | Program-mode select, sampled at the selection edge |
| fsel0_sd_i | input | 1 | Flag select 0; serial data bit during serial loading |
| fsel1_sen_i | input | 1 | Flag select 1; active-low serial enable during serial loading |
| wr_en_i | input | 1 | Port write strobe |
| wr_data_i | input | 18 | Port write data; the low 9 bits feed parallel loading |
| ofs_af_a_o | output | 9 | Almost-full threshold, port A |
| ofs_ae_b_o | output | 9 | Almost-empty threshold, port B |
| ofs_af_b_o | output | 9 | Almost-full threshold, port B |
| ofs_ae_a_o | output | 9 | Almost-empty threshold, port A |
| prog_done_o | output | 1 | Loading is complete |
| rdy_gate_o | output | 1 | Enable for the FIFOs' write-ready flags |
| mem_wr_o | output | 1 | Write strobe passed through to FIFO memory |

## Verification
The assertions assume two things about the inputs: the pins are stable around the selection edge, and reset is released between clock edges. The bench meets both by changing every input only on the falling clock edge and by setting the mode pins while reset is still held.

The assertions also assume the serial enable is a clean level, so the shift count can be trusted. The bench shifts data only on cycles it drives deliberately, and it fills the gap cycles (enable high) with junk data and stray write strobes. Every mode-pin combination is swept across the three loading methods.

// File: rtl/ofl_pkg.sv
package ofl_pkg;

  localparam int NUM_OFS = 4;

  // Load order of the registers; serial and parallel loading share it.
  localparam int SLOT_AF_A = 0;
  localparam int SLOT_AE_B = 1;
  localparam int SLOT_AF_B = 2;
  localparam int SLOT_AE_A = 3;

  typedef enum logic [1:0] {
    LD_PRESET   = 2'd0,
    LD_PARALLEL = 2'd1,
    LD_SERIAL   = 2'd2
  } ld_mode_e;

  typedef enum logic [2:0] {
    ST_SELECT = 3'd0,
    ST_PAR    = 3'd1,
    ST_SER    = 3'd2,
    ST_SETTLE = 3'd3,
    ST_RUN    = 3'd4
  } ld_state_e;

endpackage

// File: rtl/ofl_mode_dec.sv
module ofl_mode_dec
  import ofl_pkg::*;
#(
  parameter int OFS_W       = 9,
  parameter int PRESET_BOTH = 64,
  parameter int PRESET_HI   = 16,
  parameter int PRESET_LO   = 8
) (
  input  logic             prog_mode_i,
  input  logic             fsel0_i,
  input  logic             fsel1_i,
  output ld_mode_e         mode_o,
  output logic [OFS_W-1:0] preset_o
);

  always_comb begin
    mode_o   = LD_SERIAL;
    preset_o = '0;
    if (prog_mode_i) begin
      if (!fsel0_i && !fsel1_i) begin
        mode_o = LD_PARALLEL;
      end else begin
        mode_o = LD_PRESET;
        unique case ({fsel1_i, fsel0_i})
          2'b11:   preset_o = OFS_W'(PRESET_BOTH);
          2'b10:   preset_o = OFS_W'(PRESET_HI);
          default: preset_o = OFS_W'(PRESET_LO);
        endcase
      end
    end
  end

endmodule

// File: rtl/ofl_seq.sv
module ofl_seq
  import ofl_pkg::*;
#(
  parameter int OFS_W = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ld_mode_e                   mode_i,
  input  logic                       sen_n_i,
  input  logic                       wr_en_i,
  output logic                       preset_we_o,
  output logic                       par_we_o,
  output logic [$clog2(NUM_OFS)-1:0] par_slot_o,
  output logic                       shift_o,
  output logic                       done_o
);

  localparam int TOTAL_BITS = NUM_OFS * OFS_W;
  localparam int CNT_W      = $clog2(TOTAL_BITS + 1);
  localparam int SLOT_W     = $clog2(NUM_OFS);

  ld_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    cnt_en      = 1'b0;
    preset_we_o = 1'b0;
    par_we_o    = 1'b0;
    shift_o     = 1'b0;
    unique case (state_q)
      ST_SELECT: begin
        cnt_en = 1'b1;
        cnt_d  = '0;
        unique case (mode_i)
          LD_PRESET: begin
            preset_we_o = 1'b1;
            state_d     = ST_RUN;
          end
          LD_PARALLEL: state_d = ST_PAR;
          default:     state_d = ST_SER;
        endcase
      end
      ST_PAR: begin
        if (wr_en_i) begin
          par_we_o = 1'b1;
          cnt_en   = 1'b1;
          cnt_d    = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(NUM_OFS - 1)) state_d = ST_RUN;
        end
      end
      ST_SER: begin
        if (!sen_n_i) begin
          shift_o = 1'b1;
          cnt_en  = 1'b1;
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(TOTAL_BITS - 1)) state_d = ST_SETTLE;
        end
      end
      ST_SETTLE: state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SELECT;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign par_slot_o = cnt_q[SLOT_W-1:0];
  assign done_o     = (state_q == ST_RUN);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(TOTAL_BITS));

  // R2
  preset_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SELECT && mode_i == LD_PRESET) |=> done_o);

  // R6
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SER && sen_n_i) |=> $stable(cnt_q));

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  // R9
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({preset_we_o, par_we_o, shift_o}));

endmodule

// File: rtl/ofl_regfile.sv
module ofl_regfile
  import ofl_pkg::*;
#(
  parameter int OFS_W = 9
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              preset_we_i,
  input  logic [OFS_W-1:0]                  preset_i,
  input  logic                              par_we_i,
  input  logic [$clog2(NUM_OFS)-1:0]        par_slot_i,
  input  logic [OFS_W-1:0]                  par_data_i,
  input  logic                              shift_i,
  input  logic                              sd_i,
  output logic [NUM_OFS-1:0][OFS_W-1:0]     ofs_o
);

  logic [NUM_OFS-1:0][OFS_W-1:0] ofs_q, ofs_d;
  logic [NUM_OFS-1:0]            ofs_en;
  logic [NUM_OFS-1:0]            chain_in;

  for (genvar i = 0; i < NUM_OFS; i++) begin : g_slot
    // The serial chain runs from slot 0 (first loaded) to the last slot;
    // the newest bit enters the LSB of the last slot.
    if (i == NUM_OFS - 1) begin : g_tail
      assign chain_in[i] = sd_i;
    end else begin : g_link
      assign chain_in[i] = ofs_q[i+1][OFS_W-1];
    end

    always_comb begin
      ofs_en[i] = 1'b0;
      ofs_d[i]  = ofs_q[i];
      if (preset_we_i) begin
        ofs_en[i] = 1'b1;
        ofs_d[i]  = preset_i;
      end else if (par_we_i && (par_slot_i == i)) begin
        ofs_en[i] = 1'b1;
        ofs_d[i]  = par_data_i;
      end else if (shift_i) begin
        ofs_en[i] = 1'b1;
        ofs_d[i]  = {ofs_q[i][OFS_W-2:0], chain_in[i]};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ofs_q[i] <= '0;
      end else if (ofs_en[i]) begin
        ofs_q[i] <= ofs_d[i];
      end
    end
  end

  assign ofs_o = ofs_q;

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!preset_we_i && !par_we_i && !shift_i) |=> $stable(ofs_q));

  // R4
  par_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_we_i |=> ($countones(ofs_q ^ $past(ofs_q)) <= OFS_W));

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofl_pkg::*;
#(
  parameter int OFS_W       = 9,
  parameter int DATA_W      = 18,
  parameter int PRESET_BOTH = 64,
  parameter int PRESET_HI   = 16,
  parameter int PRESET_LO   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode_i,
  input  logic              fsel0_sd_i,
  input  logic              fsel1_sen_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [OFS_W-1:0]  ofs_af_a_o,
  output logic [OFS_W-1:0]  ofs_ae_b_o,
  output logic [OFS_W-1:0]  ofs_af_b_o,
  output logic [OFS_W-1:0]  ofs_ae_a_o,
  output logic              prog_done_o,
  output logic              rdy_gate_o,
  output logic              mem_wr_o
);

  localparam int SLOT_W = $clog2(NUM_OFS);

  ld_mode_e                      mode;
  logic [OFS_W-1:0]              preset_val;
  logic                          preset_we;
  logic                          par_we;
  logic [SLOT_W-1:0]             par_slot;
  logic                          shift;
  logic                          done;
  logic [NUM_OFS-1:0][OFS_W-1:0] ofs;

  if (DATA_W > OFS_W) begin : g_hi_bits
    logic unused_hi;
    assign unused_hi = ^wr_data_i[DATA_W-1:OFS_W];
  end

  ofl_mode_dec #(
    .OFS_W       (OFS_W),
    .PRESET_BOTH (PRESET_BOTH),
    .PRESET_HI   (PRESET_HI),
    .PRESET_LO   (PRESET_LO)
  ) u_dec (
    .prog_mode_i (prog_mode_i),
    .fsel0_i     (fsel0_sd_i),
    .fsel1_i     (fsel1_sen_i),
    .mode_o      (mode),
    .preset_o    (preset_val)
  );

  ofl_seq #(.OFS_W(OFS_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .sen_n_i     (fsel1_sen_i),
    .wr_en_i     (wr_en_i),
    .preset_we_o (preset_we),
    .par_we_o    (par_we),
    .par_slot_o  (par_slot),
    .shift_o     (shift),
    .done_o      (done)
  );

  ofl_regfile #(.OFS_W(OFS_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .preset_we_i (preset_we),
    .preset_i    (preset_val),
    .par_we_i    (par_we),
    .par_slot_i  (par_slot),
    .par_data_i  (wr_data_i[OFS_W-1:0]),
    .shift_i     (shift),
    .sd_i        (fsel0_sd_i),
    .ofs_o       (ofs)
  );

  assign ofs_af_a_o  = ofs[SLOT_AF_A];
  assign ofs_ae_b_o  = ofs[SLOT_AE_B];
  assign ofs_af_b_o  = ofs[SLOT_AF_B];
  assign ofs_ae_a_o  = ofs[SLOT_AE_A];
  assign prog_done_o = done;
  assign rdy_gate_o  = done;
  assign mem_wr_o    = wr_en_i & done;

  // R10
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(ofs));

  // R1
  gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !$past(mem_wr_o));

endmodule

// File: tb/ofs_loader_bench.sv
module ofs_loader_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_mode, fs0, fs1, wr_en;
  logic [17:0] wr_data;
  logic [8:0]  af_a, ae_b, af_b, ae_a;
  logic        done, rdy, mem_wr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ofs_loader u_ofs_loader (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_mode_i (prog_mode),
    .fsel0_sd_i  (fs0),
    .fsel1_sen_i (fs1),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .ofs_af_a_o  (af_a),
    .ofs_ae_b_o  (ae_b),
    .ofs_af_b_o  (af_b),
    .ofs_ae_a_o  (ae_a),
    .prog_done_o (done),
    .rdy_gate_o  (rdy),
    .mem_wr_o    (mem_wr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk_ofs(input string req, input int y1, input int x1,
                         input int y2, input int x2);
    chk({req, " af_a"}, af_a, y1);
    chk({req, " ae_b"}, ae_b, x1);
    chk({req, " af_b"}, af_b, y2);
    chk({req, " ae_a"}, ae_a, x2);
  endtask

  task automatic chk_flags(input string req, input int d);
    chk({req, " done"}, done, d);
    chk({req, " rdy"}, rdy, d);
  endtask

  // Hold reset with the mode pins applied, then release it between edges.
  task automatic do_reset(input logic pm, input logic f0, input logic f1);
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    prog_mode = pm; fs0 = f0; fs1 = f1;
    step(); step();
    chk_ofs("R1 in reset", 0, 0, 0, 0);
    chk_flags("R1 in reset", 0);
    wr_en = 1'b1;
    #1 chk("R1 mem_wr in reset", mem_wr, 0);
    wr_en = 1'b0;
    rst_n = 1'b1;
    #1 chk_flags("R1 before selection edge", 0);
  endtask

  // After done: toggle everything and confirm nothing moves.
  task automatic chk_frozen(input int y1, input int x1, input int y2, input int x2);
    for (int k = 0; k < 4; k++) begin
      prog_mode = k[0]; fs0 = ~k[1]; fs1 = 1'b0; wr_en = 1'b1;
      wr_data = 18'(k * 77 + 3);
      #1 chk("R9 mem_wr follows strobe", mem_wr, 1);
      step();
    end
    wr_en = 1'b0;
    #1 chk("R9 mem_wr low without strobe", mem_wr, 0);
    chk_ofs("R10 frozen", y1, x1, y2, x2);
    chk_flags("R10 done stays", 1);
  endtask

  task automatic run_preset(input logic f0, input logic f1, input int exp);
    do_reset(1'b1, f0, f1);
    wr_en = 1'b1; wr_data = 18'h1FF;
    step();
    wr_en = 1'b0;
    if (exp == 64) begin
      chk_ofs("R2 preset value", exp, exp, exp, exp);
      chk_flags("R2 done at selection edge", 1);
    end else begin
      chk_ofs("R3 preset value", exp, exp, exp, exp);
      chk_flags("R3 done at selection edge", 1);
    end
    chk_frozen(exp, exp, exp, exp);
  endtask

  task automatic run_parallel(input int seed);
    int v[4];
    for (int i = 0; i < 4; i++) v[i] = ((seed * 131 + i * 97) % 508) + 1;
    do_reset(1'b1, 1'b0, 1'b0);
    wr_en = 1'b1; wr_data = 18'h3FFFF;   // strobe at the selection edge: ignored
    step();
    chk_ofs("R9 selection-edge strobe ignored", 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) begin
      wr_en = 1'b0; wr_data = 18'h2AAAA;  // idle cycle must not advance
      step();
      chk_flags("R5 not yet done", 0);
      wr_en = 1'b1;
      wr_data = {9'((seed * 53 + i) | 1), 9'(v[i])};
      #1 chk("R9 mem_wr blocked while loading", mem_wr, 0);
      step();
      chk_flags("R5 done timing", (i == 3) ? 1 : 0);
    end
    wr_en = 1'b0;
    chk_ofs("R4 parallel order", v[0], v[1], v[2], v[3]);
    chk_frozen(v[0], v[1], v[2], v[3]);
  endtask

  task automatic run_serial(input logic f0, input logic f1, input int seed);
    int v[4];
    logic [35:0] stream;
    for (int i = 0; i < 4; i++) v[i] = ((seed * 211 + i * 149) % 508) + 1;
    stream = {9'(v[0]), 9'(v[1]), 9'(v[2]), 9'(v[3])};
    do_reset(1'b0, f0, f1);
    step();   // selection edge, pins as applied in reset: no shift
    chk_ofs("R6 no shift at selection edge", 0, 0, 0, 0);
    for (int b = 35; b >= 0; b--) begin
      if ((b + seed) % 5 == 2) begin
        fs1 = 1'b1; fs0 = ~stream[b]; wr_en = 1'b1; wr_data = 18'h15555;
        #1 chk("R9 mem_wr blocked in serial", mem_wr, 0);
        step();
      end
      fs1 = 1'b0; fs0 = stream[b]; wr_en = (b % 3 == 0); wr_data = 18'h3FFFF;
      step();
      chk_flags("R8 low while shifting", 0);
    end
    fs1 = 1'b0; fs0 = 1'b1; wr_en = 1'b0;   // extra bit: must be ignored
    step();
    chk_flags("R8 done one edge after last bit", 1);
    chk_ofs("R7 serial stream", v[0], v[1], v[2], v[3]);
    chk_frozen(v[0], v[1], v[2], v[3]);
  endtask

  initial begin
    rst_n = 1'b0; prog_mode = 1'b0; fs0 = 1'b0; fs1 = 1'b0;
    wr_en = 1'b0; wr_data = '0;
    run_preset(1'b1, 1'b1, 64);
    run_preset(1'b0, 1'b1, 16);
    run_preset(1'b1, 1'b0, 8);
    for (int s = 0; s < 4; s++) run_parallel(s + 1);
    run_serial(1'b0, 1'b1, 1);
    run_serial(1'b0, 1'b0, 2);
    run_serial(1'b1, 1'b1, 3);
    run_serial(1'b1, 1'b0, 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule